// File: doc/BRIEF.md
# Line-Tagged Receive Silo

This block is the shared receive queue of an eight-line asynchronous multiplexer. Each line's receiver hands over a finished character in parallel, as a one-cycle strobe with three error indications: parity, framing (break) and overrun. Each line also watches its carrier-detect input. The block holds each arrival in a per-line holding register. An arbiter then moves the holding registers into one first-in first-out store, one entry per cycle. Every stored entry carries its source line number and status flags.

The host sees one 16-bit receive word. Each read pulse pops the oldest entry into that word, with the top bit set. When the store is empty the read returns a word with the top bit clear, so software can drain the queue by reading until the value is non-negative. A write pulse at the same address does not touch the queue. It loads a write-only fill threshold that, together with an enable input, drives a registered receive interrupt.

Top module: `rx_silo`

## Requirements
- R1: A read pulse on a non-empty silo pops the oldest entry. From the next cycle until the next read, `rd_data` holds that entry with bit 15 set. A read pulse on an empty silo makes `rd_data` read 16'h0000.
- R2: Layout of a valid read word: bits 7:0 are the character, bits 10:8 the source line, bit 11 the data-set-change marker, bit 12 parity error, bit 13 framing error and bit 14 overrun.
- R3: Entries are read back in the order they entered the silo. The silo holds 64 entries.
- R4: Requests that are pending in the same cycle enter the silo one per cycle, lowest line first. Within one line, a data-set-change entry goes in before a character.
- R5: When an entry is ready while the silo already holds 64 entries, that entry is discarded and bit 14 of the newest stored entry is set.
- R6: If a line strobes a new character while its previous one is still waiting in the holding register, the new character replaces the old one and its overrun bit (bit 14) is set.
- R7: A data-set-change entry is made only when the line's modem-change enable is high and its carrier input changes level. Its low byte is 8'h00 or 8'h01, giving the new carrier level, and bits 12 to 14 are clear.
- R8: A write pulse loads `host_wdata[6:0]` as the interrupt threshold and does not change the silo or the read word. Reset sets the threshold to 1.
- R9: `irq` is a register. Each cycle it is loaded with `rx_ie` AND (the number of stored entries is at least the threshold), using the values of the previous cycle.
- R10: After reset the silo is empty, and `rd_data` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_stb | input | 8 | Per-line character-ready strobe |
| chr_bus | input | 64 | Per-line character, line n in bits 8n+7:8n |
| chr_pe | input | 8 | Per-line parity error |
| chr_fe | input | 8 | Per-line framing error |
| chr_ovr | input | 8 | Per-line receiver overrun |
| carrier | input | 8 | Per-line carrier-detect level |
| mdm_en | input | 8 | Per-line modem-change enable |
| rx_ie | input | 1 | Receive interrupt enable |
| host_rd | input | 1 | Read pulse: pop one entry |
| host_wr | input | 1 | Write pulse: load threshold |
| host_wdata | input | 16 | Write data |
| rd_data | output | 16 | Receive word |
| irq | output | 1 | Receive interrupt |

## Verification
The bench fills the silo to 65 arrivals and checks that only the 64th entry carries the overrun mark and that the 65th is gone. A design that advanced its write pointer would wrap and overwrite the oldest entry instead. It strobes lines 5, 2 and 7 together and strobes a carrier change and a character on one line together. An arbiter with reversed priority, or one that dropped simultaneous requests, would show up in the read order. It re-strobes a line that is still waiting in its holding register, which exposes a holding register that silently drops the character or forgets the overrun mark. It also moves the threshold and the enable around the fill level, which catches a comparison that is off by one and an interrupt that ignores the enable.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int LINE_W = 3;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic              dsc;
    logic [LINE_W-1:0] line;
    logic [7:0]        ch;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/rx_silo_line.sv
module rx_silo_line
  import rx_silo_pkg::*;
#(
  parameter int LINE = 0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   stb,
  input  logic [7:0] ch,
  input  logic   pe,
  input  logic   fe,
  input  logic   ovr_in,
  input  logic   carrier,
  input  logic   mdm_en,
  input  logic   grant_chr,
  input  logic   grant_dsc,
  output logic   req_chr,
  output logic   req_dsc,
  output entry_t chr_word,
  output entry_t dsc_word
);
  localparam logic [LINE_W-1:0] TAG = LINE_W'(LINE);

  logic chr_pend, dsc_pend, car_prev, car_lvl;

  // Character holding register; a re-strobe before grant overwrites and marks overrun
  always_ff @(posedge clk) begin
    if (rst) begin
      chr_pend <= 1'b0;
      chr_word <= '0;
    end else if (stb) begin
      chr_pend <= 1'b1;
      chr_word <= '{ovr: ovr_in | (chr_pend & ~grant_chr), fe: fe, pe: pe,
                    dsc: 1'b0, line: TAG, ch: ch};
    end else if (grant_chr) begin
      chr_pend <= 1'b0;
    end
  end

  // Carrier change detector
  always_ff @(posedge clk) begin
    car_prev <= carrier;
    if (rst) begin
      dsc_pend <= 1'b0;
      car_lvl  <= 1'b0;
    end else if (mdm_en && (carrier != car_prev)) begin
      dsc_pend <= 1'b1;
      car_lvl  <= carrier;
    end else if (grant_dsc) begin
      dsc_pend <= 1'b0;
    end
  end

  assign req_chr  = chr_pend;
  assign req_dsc  = dsc_pend;
  assign dsc_word = '{ovr: 1'b0, fe: 1'b0, pe: 1'b0, dsc: 1'b1, line: TAG,
                      ch: {7'd0, car_lvl}};

  a_r6_restrobe_marks_overrun: assert property (@(posedge clk) disable iff (rst)
    (stb && chr_pend && !grant_chr) |=> chr_word.ovr);
endmodule

// File: rtl/rx_silo_arb.sv
module rx_silo_arb #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // Fixed priority: lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  a_r4_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  a_r4_grant_when_req: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|grant));
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  entry_t             push_word,
  input  logic               pop,
  output logic [15:0]        rd_word,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);

  entry_t        mem [DEPTH];
  entry_t        last_word;
  logic [AW-1:0] wptr, rptr;
  logic          full, do_push, do_mark, do_pop;

  assign full    = (count == FULL);
  assign do_push = push && !full;
  assign do_mark = push && full;
  assign do_pop  = pop && (count != '0);

  // Single write port: a normal push, or a rewrite of the newest entry with overrun
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wptr] <= push_word;
    end else if (do_mark) begin
      mem[wptr - ONE] <= '{ovr: 1'b1, fe: last_word.fe, pe: last_word.pe,
                           dsc: last_word.dsc, line: last_word.line, ch: last_word.ch};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      last_word <= '0;
      rd_word   <= '0;
    end else begin
      if (do_push) begin
        wptr      <= wptr + ONE;
        last_word <= push_word;
      end else if (do_mark) begin
        last_word.ovr <= 1'b1;
      end
      if (pop) rd_word <= do_pop ? {1'b1, mem[rptr]} : 16'h0000;
      if (do_pop) rptr <= rptr + ONE;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  a_r5_full_holds_wptr: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> $stable(wptr));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DEPTH  = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NLINES-1:0]   chr_stb,
  input  logic [NLINES*8-1:0] chr_bus,
  input  logic [NLINES-1:0]   chr_pe,
  input  logic [NLINES-1:0]   chr_fe,
  input  logic [NLINES-1:0]   chr_ovr,
  input  logic [NLINES-1:0]   carrier,
  input  logic [NLINES-1:0]   mdm_en,
  input  logic                rx_ie,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [15:0]         host_wdata,
  output logic [15:0]         rd_data,
  output logic                irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int NRQ = 2 * NLINES;

  logic [NRQ-1:0] req, grant;
  entry_t         words [NRQ];
  entry_t         push_word;
  logic [AW:0]    count;
  logic [PW-1:0]  thresh;

  // Request index 2n is line n's carrier change, 2n+1 its character
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    rx_silo_line #(.LINE(g)) u_line (
      .clk(clk), .rst(rst), .stb(chr_stb[g]), .ch(chr_bus[g*8 +: 8]),
      .pe(chr_pe[g]), .fe(chr_fe[g]), .ovr_in(chr_ovr[g]),
      .carrier(carrier[g]), .mdm_en(mdm_en[g]),
      .grant_chr(grant[2*g+1]), .grant_dsc(grant[2*g]),
      .req_chr(req[2*g+1]), .req_dsc(req[2*g]),
      .chr_word(words[2*g+1]), .dsc_word(words[2*g]));
  end

  rx_silo_arb #(.N(NRQ)) u_arb (.clk(clk), .rst(rst), .req(req), .grant(grant));

  always_comb begin
    push_word = '0;
    for (int i = 0; i < NRQ; i++)
      if (grant[i]) push_word = words[i];
  end

  rx_silo_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(|grant), .push_word(push_word),
    .pop(host_rd), .rd_word(rd_data), .count(count));

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh <= PW'(1);
      irq    <= 1'b0;
    end else begin
      if (host_wr) thresh <= host_wdata[PW-1:0];
      irq <= rx_ie && (count >= thresh);
    end
  end

  a_r1_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd && count == '0) |=> (rd_data == 16'h0000));
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !rx_ie |=> !irq);
endmodule

// File: tb/rx_silo_bench.sv
module rx_silo_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  chr_stb, chr_pe, chr_fe, chr_ovr, carrier, mdm_en;
  logic [63:0] chr_bus;
  logic        rx_ie, host_rd, host_wr;
  logic [15:0] host_wdata, rd_data;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rx_silo u_rx_silo (.*);

  // {line[2:0], pe, fe, ovr, ch[7:0], expected word[15:0]}
  localparam logic [29:0] VEC [7] = '{
    {3'd0, 3'b000, 8'h41, 16'h8041},
    {3'd7, 3'b100, 8'hFF, 16'h97FF},
    {3'd3, 3'b010, 8'h00, 16'hA300},
    {3'd5, 3'b001, 8'h5A, 16'hC55A},
    {3'd2, 3'b110, 8'h80, 16'hB280},
    {3'd6, 3'b111, 8'h33, 16'hF633},
    {3'd1, 3'b000, 8'h7E, 16'h817E}};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(input int l, input logic [7:0] c, input logic [2:0] flags);
    chr_bus[l*8 +: 8] = c;
    {chr_pe[l], chr_fe[l], chr_ovr[l]} = flags;
  endtask

  task automatic pulse(input logic [7:0] mask);
    @(negedge clk) chr_stb = mask;
    @(negedge clk) chr_stb = '0;
  endtask

  task automatic rd(output logic [15:0] w);
    @(negedge clk) host_rd = 1'b1;
    @(negedge clk) host_rd = 1'b0;
    w = rd_data;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk) begin host_wr = 1'b1; host_wdata = d; end
    @(negedge clk) host_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    rst = 1'b1; chr_stb = '0; chr_bus = '0; chr_pe = '0; chr_fe = '0; chr_ovr = '0;
    carrier = '0; mdm_en = '0; rx_ie = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    host_wdata = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R10: reset state
    chk("R10 rd_data after reset", rd_data, 16'h0000);
    chk("R10 irq after reset", {15'd0, irq}, 16'h0000);
    rd(w);
    chk("R1 R10 empty read", w, 16'h0000);

    // R2: field layout, one vector per pass
    foreach (VEC[i]) begin
      set_line(int'(VEC[i][29:27]), VEC[i][23:16], VEC[i][26:24]);
      pulse(8'h01 << VEC[i][29:27]);
      idle(2);
      rd(w);
      chk("R2 field layout", w, VEC[i][15:0]);
    end
    chr_pe = '0; chr_fe = '0; chr_ovr = '0;

    // R4: simultaneous lines ascending
    set_line(5, 8'h55, 3'b000); set_line(2, 8'h22, 3'b000); set_line(7, 8'h77, 3'b000);
    pulse(8'hA4);
    idle(4);
    rd(w); chk("R4 first line 2", w, 16'h8222);
    rd(w); chk("R4 second line 5", w, 16'h8555);
    rd(w); chk("R4 third line 7", w, 16'h8777);
    rd(w); chk("R1 drained", w, 16'h0000);

    // R4 R7: carrier change before character on the same line
    mdm_en[4] = 1'b1;
    set_line(4, 8'h44, 3'b000);
    @(negedge clk) begin carrier[4] = 1'b1; chr_stb = 8'h10; end
    @(negedge clk) chr_stb = '0;
    idle(3);
    rd(w); chk("R4 R7 change first", w, 16'h8C01);
    rd(w); chk("R4 char second", w, 16'h8444);

    // R7: change ignored while disabled
    @(negedge clk) carrier[6] = 1'b1;
    idle(3);
    rd(w); chk("R7 disabled no entry", w, 16'h0000);
    mdm_en[6] = 1'b1;
    @(negedge clk) carrier[6] = 1'b0;
    idle(3);
    rd(w); chk("R7 enabled falling", w, 16'h8E00);
    rd(w); chk("R7 single entry", w, 16'h0000);

    // R6: re-strobe while waiting
    set_line(1, 8'h01, 3'b000); set_line(3, 8'h10, 3'b000);
    @(negedge clk) chr_stb = 8'h0A;
    @(negedge clk) begin chr_bus[31:24] = 8'h11; chr_stb = 8'h08; end
    @(negedge clk) chr_stb = '0;
    idle(3);
    rd(w); chk("R6 line 1 intact", w, 16'h8101);
    rd(w); chk("R6 replaced with overrun", w, 16'hC311);
    rd(w); chk("R6 no extra entry", w, 16'h0000);

    // R3 R5: fill past 64 entries
    for (int i = 0; i < 65; i++) begin
      @(negedge clk) begin chr_bus[7:0] = 8'(i); chr_stb = 8'h01; end
    end
    @(negedge clk) chr_stb = '0;
    idle(3);
    for (int i = 0; i < 64; i++) begin
      rd(w);
      chk(i == 63 ? "R5 newest marked" : "R3 order", w,
          (i == 63) ? 16'hC03F : (16'h8000 | 16'(i)));
    end
    rd(w); chk("R5 arrival discarded", w, 16'h0000);

    // R9: interrupt with default threshold
    rx_ie = 1'b1;
    set_line(0, 8'hAA, 3'b000);
    pulse(8'h01);
    idle(2);
    chk("R9 R8 irq at default 1", {15'd0, irq}, 16'h0001);
    rd(w);
    idle(2);
    chk("R9 irq clears", {15'd0, irq}, 16'h0000);

    // R8: threshold 3, write does not touch read word
    wr(16'h0003);
    rd(w); chk("R8 write-only", w, 16'h0000);
    pulse(8'h03);
    idle(4);
    chk("R9 below threshold", {15'd0, irq}, 16'h0000);
    pulse(8'h04);
    idle(3);
    chk("R9 at threshold", {15'd0, irq}, 16'h0001);
    rx_ie = 1'b0;
    idle(2);
    chk("R9 disabled", {15'd0, irq}, 16'h0000);
    rx_ie = 1'b1;
    rd(w);
    idle(2);
    chk("R9 drop below", {15'd0, irq}, 16'h0000);
    rd(w); rd(w);

    // R8 R10: reset restores threshold 1
    do_reset();
    pulse(8'h01);
    idle(3);
    chk("R8 reset threshold", {15'd0, irq}, 16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule